// File: doc/BRIEF.md
# Pending-Interrupt Controller with Offset

This block gathers single-cycle request pulses from up to `N` peripheral sources into a source-pending register and drives one level-sensitive interrupt line toward the CPU. Whenever a request arrives, or software clears source-pending bits, the controller looks at the pending set again. It picks the lowest-numbered pending source, marks that source in a separate interrupt-pending register, and publishes its binary index in an offset register. The offset is what the interrupt handler reads to find out which source it is serving.

Software reaches the three registers through a small word bus. Writes are synchronous, with one write enable, a two-bit register select and write data. Reads are combinational from the register select. The handler acknowledges work by writing ones to the bits it wants cleared. The offset register can only be read.

Top module: `irqc_top`

## Requirements
- R1: A pulse on request input n, sampled at a rising clock edge, sets bit n of the source-pending register (register select 0). The bit is visible on the read bus after that edge.
- R2: On an evaluation cycle, the offset register (register select 2, index in the low bits, upper bits zero) takes the index of the lowest-numbered set bit of the updated source-pending value. An evaluation cycle is any cycle with at least one request, or with a write to select 0.
- R3: On an evaluation cycle with a non-zero updated source-pending value, the bit of the chosen source is set in the interrupt-pending register (register select 1). Its other bits are kept.
- R4: The `irq_o` output is high exactly when the source-pending register is non-zero, and it changes at the same edge as that register.
- R5: A write to select 0 clears exactly the source-pending bits whose write-data bits are one, and leaves all other bits unchanged.
- R6: After a write to select 0 that leaves pending sources, the offset and the interrupt-pending bit move to the new lowest pending source at that same edge. If nothing is left pending, the offset keeps its value.
- R7: A request that arrives while nothing is pending makes its source the active one at the same edge: the source-pending bit, the interrupt-pending bit, the offset and `irq_o` all update together.
- R8: When a request and a write-one-to-clear hit the same source-pending bit in the same cycle, the request wins and the bit stays set.
- R9: Writing ones to select 1 clears those interrupt-pending bits and causes no re-evaluation. Writes to select 2 have no effect on any register.
- R10: After reset, all three registers read zero and `irq_o` is low.
- R11: Reads of register select 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_req_i | input | N | Single-cycle request pulses, one bit per source |
| bus_we_i | input | 1 | Register write enable |
| bus_addr_i | input | 2 | Register select: 0 source-pending, 1 interrupt-pending, 2 offset, 3 unused |
| bus_wdata_i | input | DW | Write data (ones mark bits to clear) |
| bus_rdata_o | output | DW | Read data for the selected register |
| irq_o | output | 1 | Level interrupt line to the CPU |

## Verification
Every register and `irq_o` changes at the first rising edge after the request or write that causes the change, because there is one register stage between the inputs and each result. Read data then follows the register select with no further delay. The bench drives its inputs shortly after a rising edge and compares the outputs at the falling edge. A behavioural model, stepped at each rising edge, gives the expected values at that falling edge. Directed checks read each register back through the bus at the same falling-edge point, so every result is sampled one edge after its cause.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_INT  = 2'd1,
    SEL_OFS  = 2'd2,
    SEL_NONE = 2'd3
  } irqc_sel_e;
endpackage

// File: rtl/irqc_lowest.sv
module irqc_lowest #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  // isolate lowest set bit
  assign onehot_o = vec_i & (~vec_i + {{(N-1){1'b0}}, 1'b1});
  assign any_o    = |vec_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irqc_srcpnd.sv
module irqc_srcpnd #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] src_q_o,
  output logic [N-1:0] src_next_o,
  output logic         irq_o
);
  logic [N-1:0] src_q;
  logic         irq_q;
  logic         irq_d;

  always_comb begin
    src_next_o = src_q;
    if (clr_en_i) src_next_o = src_next_o & ~clr_mask_i;
    src_next_o = src_next_o | req_i;  // set beats clear
    irq_d      = |src_next_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      irq_q <= 1'b0;
    end else begin
      src_q <= src_next_o;
      irq_q <= irq_d;
    end
  end

  assign src_q_o = src_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/irqc_intpnd.sv
module irqc_intpnd #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eval_en_i,
  input  logic          sel_any_i,
  input  logic [N-1:0]  sel_onehot_i,
  input  logic [IW-1:0] sel_idx_i,
  input  logic          clr_en_i,
  input  logic [N-1:0]  clr_mask_i,
  output logic [N-1:0]  int_q_o,
  output logic [IW-1:0] ofs_q_o
);
  logic [N-1:0]  int_q, int_d;
  logic [IW-1:0] ofs_q, ofs_d;
  logic          upd_en;

  assign upd_en = eval_en_i & sel_any_i;

  always_comb begin
    int_d = int_q;
    ofs_d = ofs_q;
    if (clr_en_i) int_d = int_d & ~clr_mask_i;
    if (upd_en) begin
      int_d = int_d | sel_onehot_i;
      ofs_d = sel_idx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= '0;
      ofs_q <= '0;
    end else begin
      int_q <= int_d;
      if (upd_en) ofs_q <= ofs_d;
    end
  end

  assign int_q_o = int_q;
  assign ofs_q_o = ofs_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int N  = 32,
  parameter int DW = 32,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_req_i,
  input  logic          bus_we_i,
  input  logic [1:0]    bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o
);
  import irqc_pkg::*;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  irqc_sel_e     sel;
  logic          src_clr_en, int_clr_en, eval_en;
  logic [N-1:0]  clr_mask;
  logic [N-1:0]  src_q, src_next, int_q, sel_onehot;
  logic [IW-1:0] ofs_q, sel_idx;
  logic          sel_any;

  assign sel        = irqc_sel_e'(bus_addr_i);
  assign src_clr_en = bus_we_i && (sel == SEL_SRC);
  assign int_clr_en = bus_we_i && (sel == SEL_INT);
  assign clr_mask   = bus_wdata_i[N-1:0];
  assign eval_en    = (|irq_req_i) | src_clr_en;

  irqc_srcpnd #(.N(N)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .req_i      (irq_req_i),
    .clr_en_i   (src_clr_en),
    .clr_mask_i (clr_mask),
    .src_q_o    (src_q),
    .src_next_o (src_next),
    .irq_o      (irq_o)
  );

  irqc_lowest #(.N(N), .IW(IW)) u_low (
    .vec_i    (src_next),
    .any_o    (sel_any),
    .onehot_o (sel_onehot),
    .idx_o    (sel_idx)
  );

  irqc_intpnd #(.N(N), .IW(IW)) u_int (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .eval_en_i    (eval_en),
    .sel_any_i    (sel_any),
    .sel_onehot_i (sel_onehot),
    .sel_idx_i    (sel_idx),
    .clr_en_i     (int_clr_en),
    .clr_mask_i   (clr_mask),
    .int_q_o      (int_q),
    .ofs_q_o      (ofs_q)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (sel)
      SEL_SRC: bus_rdata_o[N-1:0]  = src_q;
      SEL_INT: bus_rdata_o[N-1:0]  = int_q;
      SEL_OFS: bus_rdata_o[IW-1:0] = ofs_q;
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N  = 32,
  parameter int DW = 32,
  parameter int IW = $clog2(N)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  req_i,
  input logic          we_i,
  input logic [1:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [N-1:0]  src_i,
  input logic [N-1:0]  int_i,
  input logic [IW-1:0] ofs_i,
  input logic          irq_i
);
  function automatic logic [N-1:0] below(input logic [IW-1:0] k);
    below = '0;
    for (int i = 0; i < N; i++) if (i < int'(k)) below[i] = 1'b1;
  endfunction

  logic src_wr;
  assign src_wr = we_i && (addr_i == 2'd0);

  assert_req_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |=> ((src_i & $past(req_i)) == $past(req_i)));

  assert_lowest_sel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i != '0) || src_wr) |=>
      ((src_i == '0) || (src_i[ofs_i] && int_i[ofs_i] && ((src_i & below(ofs_i)) == '0))));

  assert_irq_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == (src_i != '0));

  assert_w1c_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_wr && req_i == '0) |=> (src_i == ($past(src_i) & ~$past(wdata_i[N-1:0]))));

  assert_ofs_ro_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd2 && req_i == '0) |=> ($stable(ofs_i) && $stable(src_i)));
endmodule

bind irqc_top irqc_chk #(.N(N), .DW(DW), .IW(IW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_sync_n),
  .req_i   (irq_req_i),
  .we_i    (bus_we_i),
  .addr_i  (bus_addr_i),
  .wdata_i (bus_wdata_i),
  .src_i   (src_q),
  .int_i   (int_q),
  .ofs_i   (ofs_q),
  .irq_i   (irq_o)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  // behavioural model state
  logic [31:0] m_src = '0, m_int = '0;
  int          m_ofs = 0;
  bit          m_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top #(.N(N), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_src;
      2'd1: return m_int;
      2'd2: return 32'(m_ofs);
      default: return 32'd0;
    endcase
  endfunction

  // model steps at each rising edge on the inputs present before it
  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = '0; m_int = '0; m_ofs = 0; m_irq = 1'b0;
    end else begin
      logic [31:0] sclr, iclr, nxt;
      bit evt;
      sclr = (we && addr == 2'd0) ? wdata : '0;
      iclr = (we && addr == 2'd1) ? wdata : '0;
      nxt  = (m_src & ~sclr) | req;
      evt  = (req != '0) || (we && addr == 2'd0);
      m_int = m_int & ~iclr;
      if (evt && nxt != '0) begin
        for (int i = N - 1; i >= 0; i--) if (nxt[i]) m_ofs = i;
        m_int[m_ofs] = 1'b1;
      end
      m_src = nxt;
      m_irq = (nxt != '0);
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (live) begin
      chk("R4 irq level", {31'd0, irq}, {31'd0, m_irq});
      chk("R1/R2/R3 readback", rdata, model_read(addr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input logic [N-1:0] r, input bit w, input logic [1:0] a,
                      input logic [31:0] d);
    req = r; we = w; addr = a; wdata = d;
    @(posedge clk); #2;
    req = '0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    rd(2'd0, 32'h0, "R10 src reset");
    rd(2'd1, 32'h0, "R10 int reset");
    rd(2'd2, 32'h0, "R10 ofs reset");
    chk("R10 irq reset", {31'd0, irq}, 32'd0);
    live = 1'b1;
    // R7 first request activates immediately
    step(32'h20, 1'b0, 2'd0, 0);
    chk("R7 irq same edge", {31'd0, irq}, 32'd1);
    rd(2'd0, 32'h20, "R7 R1 src bit5");
    rd(2'd1, 32'h20, "R7 R3 int bit5");
    rd(2'd2, 32'd5,  "R7 R2 ofs 5");
    // R2 R3 two simultaneous requests, lowest chosen
    step(32'h204, 1'b0, 2'd0, 0);
    rd(2'd0, 32'h224, "R1 src 2,5,9");
    rd(2'd2, 32'd2,   "R2 ofs lowest 2");
    rd(2'd1, 32'h24,  "R3 int 2,5");
    // R9 clear int pending, no re-evaluation
    step('0, 1'b1, 2'd1, 32'h24);
    rd(2'd1, 32'h0, "R9 int cleared");
    rd(2'd2, 32'd2, "R9 ofs kept");
    // R9 offset read-only
    step('0, 1'b1, 2'd2, 32'd7);
    rd(2'd2, 32'd2,   "R9 ofs write ignored");
    rd(2'd0, 32'h224, "R9 src untouched");
    // R5 R6 clear bit 2 moves selection to 5
    step('0, 1'b1, 2'd0, 32'h4);
    rd(2'd0, 32'h220, "R5 only bit2 cleared");
    rd(2'd2, 32'd5,   "R6 ofs to 5");
    rd(2'd1, 32'h20,  "R6 int bit5");
    // R8 request and clear same bit
    step(32'h200, 1'b1, 2'd0, 32'h200);
    rd(2'd0, 32'h220, "R8 set wins");
    // R4 clear all, irq drops, offset kept
    step('0, 1'b1, 2'd0, 32'h220);
    chk("R4 irq low", {31'd0, irq}, 32'd0);
    rd(2'd0, 32'h0, "R4 src empty");
    rd(2'd2, 32'd5, "R6 ofs kept when empty");
    // boundaries: bits 0 and 31
    step(32'h8000_0001, 1'b0, 2'd0, 0);
    rd(2'd2, 32'd0, "R2 ofs 0");
    step('0, 1'b1, 2'd0, 32'h1);
    rd(2'd2, 32'd31, "R6 ofs 31");
    // R11 unused select
    rd(2'd3, 32'h0, "R11 unused read");
    step('0, 1'b1, 2'd0, 32'hFFFF_FFFF);
    // mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r, d;
      r = ($urandom_range(0, 2) == 0) ? (32'h1 << $urandom_range(0, 31)) : '0;
      if ($urandom_range(0, 5) == 0) r = r | $urandom;
      d = $urandom;
      if ($urandom_range(0, 3) == 0) step(r, 1'b1, 2'($urandom_range(0, 3)), d);
      else begin
        addr = 2'($urandom_range(0, 3));
        step(r, 1'b0, addr, 0);
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule